// File: doc/BRIEF.md
# Dual-Branch Switchable Clock Root

This block builds one derived clock from a set of eight source clocks. It holds two complete source paths, branch A and branch B. Each has its own source selector, an output gate and an integer pre-divider. A glitch-free two-way mux picks one branch, and a post-divider after the mux sets the final rate. Software uses a single write port to choose a new source.

Each accepted write goes to the branch that is idle. A one-bit write parity then moves the final mux over to that branch. The new source is therefore already running through its own pre-divider before the mux hands over, and the switch always happens between two live clocks.

Two status outputs report the switch. `busy` stays high from a write until the new branch alone drives the output. `active_b` reports which branch is enabled, seen from the register clock. A build option removes both pre-dividers, so each branch goes straight from its source selector to its gate.

Top module: `clk_root_slice`

## Requirements
- R1: The branch in use is set by the parity of accepted writes. Parity 0 selects branch A and parity 1 selects branch B. Reset starts at parity 0, so the first accepted write moves to branch B. While `busy` is low, `active_b` equals that parity.
- R2: An accepted write loads `wr_src` and `wr_pre_m1` into the branch that the new parity makes active. The other branch keeps its source and ratio.
- R3: A write presented while `busy` is high has no effect. The parity, both branch settings and the output rate stay as they were.
- R4: At most one branch gate is open at any time. A gate opens or closes only while its own branch clock is low, so `clk_out` has no pulse shorter than the shortest half period of the selected sources.
- R5: Source code k selects `src_clk[k]`. With the pre-dividers present, the `clk_out` period is the source period × pre ratio × post ratio.
- R6: A divider loads a new ratio only when its count expires. A ratio change mid-cycle never shortens a pulse.
- R7: `busy` rises on the cycle after an accepted write, and on reset. It falls once the target branch gate is open and the other gate is closed.
- R8: If the source of the branch being left is stopped, the switch stalls: `busy` stays high, `active_b` keeps its old value and `clk_out` stops toggling. When that source runs again, the switch completes.
- R9: With the pre-dividers left out, the `clk_out` period is the source period × post ratio.
- R10: Field value v in `wr_pre_m1` (3 bits) means divide by v+1, a range of 1 to 8. Field value v in `post_m1` (6 bits) means divide by v+1, a range of 1 to 64. After reset branch A uses source `RST_SRC_A` with a pre ratio of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register-side clock |
| cfg_rst_n | input | 1 | Active-low asynchronous reset for the whole slice |
| src_clk | input | 8 | Source clocks, indexed by source code |
| wr_en | input | 1 | Select write strobe, one `cfg_clk` cycle |
| wr_src | input | 3 | Source code for the idle branch |
| wr_pre_m1 | input | 3 | Pre-divide ratio minus one for the idle branch |
| post_m1 | input | 6 | Post-divide ratio minus one |
| clk_out | output | 1 | Derived clock |
| busy | output | 1 | Switch in progress; writes are ignored while high |
| active_b | output | 1 | High when branch B is driving the output |

## Verification
The hardest state to reach is a stalled switch. The source that the current branch still uses must stop between one write and the next, while the target branch keeps running. The bench stops one source clock after a completed switch onto it, then issues a write that points the other branch at a live source. It watches `busy`, `active_b` and the edges of `clk_out` for a long window. It then restarts the stopped source and expects the switch to finish. A pulse-width monitor runs through every source and ratio sweep, so any runt pulse during a hand-over or a ratio change is caught.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
   typedef enum logic {
      BR_A = 1'b0,
      BR_B = 1'b1
   } branch_e;

   // high-phase threshold for a down-counting divider holding ratio-1
   function automatic int unsigned hi_mark(input int unsigned ratio_m1);
      return (ratio_m1 + 1) >> 1;
   endfunction
endpackage

// File: rtl/clkroot_sel_bank.sv
module clkroot_sel_bank #(
   parameter int SEL_W     = 3,
   parameter int PRE_W     = 3,
   parameter int RST_SRC_A = 0,
   parameter int RST_SRC_B = 1,
   parameter int RST_PRE_A = 0,
   parameter int RST_PRE_B = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_src,
   input  logic [PRE_W-1:0] wr_pre_m1,
   input  logic             gate_a,
   input  logic             gate_b,
   output logic [SEL_W-1:0] src_a,
   output logic [SEL_W-1:0] src_b,
   output logic [PRE_W-1:0] pre_a,
   output logic [PRE_W-1:0] pre_b,
   output logic             pick_b,
   output logic             busy,
   output logic             active_b
);
   import clkroot_pkg::*;

   branch_e    wr_par;
   logic [1:0] a_s, b_s;
   logic       take, tgt_on, oth_on;

   assign take   = wr_en && !busy;
   assign tgt_on = (wr_par == BR_B) ? b_s[1] : a_s[1];
   assign oth_on = (wr_par == BR_B) ? a_s[1] : b_s[1];
   assign pick_b   = (wr_par == BR_B);
   assign active_b = b_s[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_s <= '0;
         b_s <= '0;
      end else begin
         a_s <= {a_s[0], gate_a};
         b_s <= {b_s[0], gate_b};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_par <= BR_A;
         busy   <= 1'b1;
         src_a  <= SEL_W'(RST_SRC_A);
         src_b  <= SEL_W'(RST_SRC_B);
         pre_a  <= PRE_W'(RST_PRE_A);
         pre_b  <= PRE_W'(RST_PRE_B);
      end else if (take) begin
         busy <= 1'b1;
         if (wr_par == BR_A) begin
            wr_par <= BR_B;
            src_b  <= wr_src;
            pre_b  <= wr_pre_m1;
         end else begin
            wr_par <= BR_A;
            src_a  <= wr_src;
            pre_a  <= wr_pre_m1;
         end
      end else if (tgt_on && !oth_on) begin
         busy <= 1'b0;
      end
   end

   // R7
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy);
   // R3
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> ($stable(wr_par) && $stable(src_a) && $stable(src_b)));
   // R2
   keep_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wr_par == BR_A) |=> ($stable(src_a) && $stable(pre_a)));
   // R2
   keep_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wr_par == BR_B) |=> ($stable(src_b) && $stable(pre_b)));
   // R1
   parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (active_b == pick_b));
endmodule

// File: rtl/clkroot_div.sv
module clkroot_div #(
   parameter int W = 3
) (
   input  logic         clk_in,
   input  logic         rst_n,
   input  logic [W-1:0] ratio_m1,
   output logic         clk_out
);
   import clkroot_pkg::*;

   logic [W-1:0] cur, cnt, nxt;
   logic         q;

   assign nxt = cnt - 1'b1;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         cnt <= '0;
         q   <= 1'b1;
      end else if (cnt == '0) begin
         cur <= ratio_m1;
         cnt <= ratio_m1;
         q   <= 1'b1;
      end else begin
         cnt <= nxt;
         q   <= ({1'b0, nxt} >= (W+1)'(hi_mark(int'(cur))));
      end
   end

   assign clk_out = (cur == '0) ? clk_in : q;

   // R6
   ratio_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (cnt != '0) |=> $stable(cur));
endmodule

// File: rtl/clkroot_gfmux.sv
module clkroot_gfmux (
   input  logic clk_a,
   input  logic clk_b,
   input  logic rst_n,
   input  logic pick_b,
   output logic en_a,
   output logic en_b,
   output logic clk_out
);
   logic [1:0] a_sy, b_sy;

   always_ff @(negedge clk_a or negedge rst_n) begin
      if (!rst_n) a_sy <= '0;
      else        a_sy <= {a_sy[0], !pick_b && !en_b};
   end

   always_ff @(negedge clk_b or negedge rst_n) begin
      if (!rst_n) b_sy <= '0;
      else        b_sy <= {b_sy[0], pick_b && !en_a};
   end

   assign en_a    = a_sy[1];
   assign en_b    = b_sy[1];
   assign clk_out = (clk_a & en_a) | (clk_b & en_b);

   always_comb begin
      if (rst_n == 1'b1) begin
         // R4
         mutex_chk: assert (!(en_a && en_b));
      end
   end
endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice #(
   parameter int N_SRC      = 8,
   parameter int PRE_MAX    = 8,
   parameter int POST_MAX   = 64,
   parameter bit PRE_DIV_EN = 1'b1,
   parameter int RST_SRC_A  = 0,
   parameter int RST_SRC_B  = 1,
   localparam int SEL_W     = $clog2(N_SRC),
   localparam int PRE_W     = $clog2(PRE_MAX),
   localparam int POST_W    = $clog2(POST_MAX)
) (
   input  logic              cfg_clk,
   input  logic              cfg_rst_n,
   input  logic [N_SRC-1:0]  src_clk,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_src,
   input  logic [PRE_W-1:0]  wr_pre_m1,
   input  logic [POST_W-1:0] post_m1,
   output logic              clk_out,
   output logic              busy,
   output logic              active_b
);
   if (N_SRC < 2 || (1 << SEL_W) != N_SRC) begin : g_bad_src
      $error("N_SRC must be a power of two of at least 2");
   end
   if (PRE_MAX < 2 || (1 << PRE_W) != PRE_MAX) begin : g_bad_pre
      $error("PRE_MAX must be a power of two of at least 2");
   end
   if (POST_MAX < 2 || (1 << POST_W) != POST_MAX) begin : g_bad_post
      $error("POST_MAX must be a power of two of at least 2");
   end
   if (RST_SRC_A >= N_SRC || RST_SRC_B >= N_SRC) begin : g_bad_rst
      $error("reset source codes must be below N_SRC");
   end

   logic [SEL_W-1:0] br_src [2];
   logic [PRE_W-1:0] br_pre [2];
   logic [1:0]       br_raw, br_clk;
   logic             pick_b, en_a, en_b, mux_clk;

   clkroot_sel_bank #(
      .SEL_W(SEL_W), .PRE_W(PRE_W),
      .RST_SRC_A(RST_SRC_A), .RST_SRC_B(RST_SRC_B),
      .RST_PRE_A(0), .RST_PRE_B(0)
   ) u_bank (
      .clk(cfg_clk), .rst_n(cfg_rst_n),
      .wr_en(wr_en), .wr_src(wr_src), .wr_pre_m1(wr_pre_m1),
      .gate_a(en_a), .gate_b(en_b),
      .src_a(br_src[0]), .src_b(br_src[1]),
      .pre_a(br_pre[0]), .pre_b(br_pre[1]),
      .pick_b(pick_b), .busy(busy), .active_b(active_b)
   );

   for (genvar g = 0; g < 2; g++) begin : g_branch
      assign br_raw[g] = src_clk[br_src[g]];
      if (PRE_DIV_EN) begin : g_pre
         clkroot_div #(.W(PRE_W)) u_pre (
            .clk_in(br_raw[g]), .rst_n(cfg_rst_n),
            .ratio_m1(br_pre[g]), .clk_out(br_clk[g])
         );
      end else begin : g_nopre
         assign br_clk[g] = br_raw[g];
      end
   end

   clkroot_gfmux u_mux (
      .clk_a(br_clk[0]), .clk_b(br_clk[1]), .rst_n(cfg_rst_n),
      .pick_b(pick_b), .en_a(en_a), .en_b(en_b), .clk_out(mux_clk)
   );

   clkroot_div #(.W(POST_W)) u_post (
      .clk_in(mux_clk), .rst_n(cfg_rst_n),
      .ratio_m1(post_m1), .clk_out(clk_out)
   );
endmodule

// File: tb/clk_root_slice_test.sv
`timescale 1ns/1ps
module clk_root_slice_test;
   logic       cfg_clk = 1'b0;
   logic       cfg_rst_n = 1'b0;
   logic [7:0] src_clk = '0;
   logic [7:0] src_run = '1;
   logic       wr_en = 1'b0, wr2_en = 1'b0;
   logic [2:0] wr_src = '0, wr2_src = '0, wr_pre = '0;
   logic [5:0] post_m1 = '0, post2_m1 = '0;
   logic       clk_out, busy, active_b;
   logic       clk_out2, busy2, active_b2;

   int n_chk = 0, n_fail = 0;
   int tick = 0;
   bit par = 1'b0, par2 = 1'b0;
   bit mon_on = 1'b0;
   realtime last_t = 0.0, min_pw = 1.0e9;
   int rise_cnt = 0;

   clk_root_slice #(.PRE_DIV_EN(1'b1), .RST_SRC_A(2), .RST_SRC_B(6)) uut (
      .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .src_clk(src_clk),
      .wr_en(wr_en), .wr_src(wr_src), .wr_pre_m1(wr_pre), .post_m1(post_m1),
      .clk_out(clk_out), .busy(busy), .active_b(active_b)
   );

   clk_root_slice #(.PRE_DIV_EN(1'b0), .RST_SRC_A(2), .RST_SRC_B(6)) uut_nopre (
      .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .src_clk(src_clk),
      .wr_en(wr2_en), .wr_src(wr2_src), .wr_pre_m1(3'd0), .post_m1(post2_m1),
      .clk_out(clk_out2), .busy(busy2), .active_b(active_b2)
   );

   always #5 cfg_clk = ~cfg_clk;

   // source k has half period k+2 ns
   always #1 begin
      tick = tick + 1;
      for (int k = 0; k < 8; k++)
         if (src_run[k] && (tick % (k + 2)) == 0) src_clk[k] = ~src_clk[k];
   end

   always @(posedge clk_out or negedge clk_out) begin
      if (mon_on && ($realtime - last_t) < min_pw) min_pw = $realtime - last_t;
      last_t = $realtime;
   end
   always @(posedge clk_out) rise_cnt = rise_cnt + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input bit which, input int s, input int p);
      @(negedge cfg_clk);
      if (which) begin wr2_en = 1'b1; wr2_src = 3'(s); end
      else begin wr_en = 1'b1; wr_src = 3'(s); wr_pre = 3'(p); end
      @(negedge cfg_clk);
      wr_en = 1'b0; wr2_en = 1'b0;
   endtask

   task automatic wait_idle(input bit which);
      for (int i = 0; i < 3000; i++) begin
         @(negedge cfg_clk);
         if (!(which ? busy2 : busy)) break;
      end
   endtask

   task automatic rise(input bit which);
      if (which) @(posedge clk_out2);
      else @(posedge clk_out);
   endtask

   task automatic measure(input bit which, output int per);
      realtime t0;
      repeat (3) rise(which);
      rise(which);
      t0 = $realtime;
      rise(which);
      per = $rtoi($realtime - t0 + 0.5);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int per, exp, b;
      #32;
      // R7 R1: reset state
      check(busy == 1'b1, "R7 busy in reset", int'(busy), 1);
      check(active_b == 1'b0, "R1 branch A in reset", int'(active_b), 0);
      check(clk_out == 1'b0, "R4 gate closed in reset", int'(clk_out), 0);
      cfg_rst_n = 1'b1;
      wait_idle(1'b0);
      wait_idle(1'b1);
      check(busy == 1'b0, "R7 busy clears after reset", int'(busy), 0);
      check(active_b == 1'b0, "R1 A after reset", int'(active_b), 0);
      measure(1'b0, per);
      // R10: reset source 2, ratio 1 -> 8 ns
      check(per == 8, "R10 reset rate", per, 8);

      // first write goes to branch B
      put(1'b0, 5, 0);
      par = ~par;
      @(negedge cfg_clk);
      check(busy == 1'b1, "R7 busy after write", int'(busy), 1);
      wait_idle(1'b0);
      check(active_b == 1'b1, "R1 first write selects B", int'(active_b), 1);
      measure(1'b0, per);
      check(per == 14, "R2 new source loaded", per, 14);

      // R3: second write while busy is dropped
      put(1'b0, 1, 2);
      par = ~par;
      put(1'b0, 7, 5);
      wait_idle(1'b0);
      check(active_b == par, "R3 parity unchanged by busy write", int'(active_b), int'(par));
      measure(1'b0, per);
      check(per == 18, "R3 busy write has no effect", per, 18);

      // R5 R4: sweep sources and pre ratios
      mon_on = 1'b1;
      min_pw = 1.0e9;
      for (int s = 0; s < 8; s++) begin
         for (int p = 0; p < 8; p++) begin
            put(1'b0, s, p);
            par = ~par;
            wait_idle(1'b0);
            check(busy == 1'b0, "R7 switch completes", int'(busy), 0);
            check(active_b == par, "R1 active follows parity", int'(active_b), int'(par));
            measure(1'b0, per);
            exp = 2 * (s + 2) * (p + 1);
            check(per == exp, "R5 rate src x pre", per, exp);
         end
      end
      check(min_pw > 1.9, "R4 no runt pulse on switch", $rtoi(min_pw * 1000.0), 2000);

      // R10 R6: post ratio sweep on source 3, pre 2
      put(1'b0, 3, 1);
      par = ~par;
      wait_idle(1'b0);
      min_pw = 1.0e9;
      for (int q = 0; q < 64; q++) begin
         post_m1 = 6'(q);
         measure(1'b0, per);
         exp = 20 * (q + 1);
         check(per == exp, "R10 post ratio", per, exp);
      end
      check(min_pw > 1.9, "R6 no runt pulse on ratio change", $rtoi(min_pw * 1000.0), 2000);
      post_m1 = '0;
      mon_on = 1'b0;

      // R9: variant without pre-dividers
      for (int s = 0; s < 8; s++) begin
         for (int q = 0; q < 3; q++) begin
            post2_m1 = 6'(q);
            put(1'b1, s, 0);
            par2 = ~par2;
            wait_idle(1'b1);
            check(active_b2 == par2, "R9 variant parity", int'(active_b2), int'(par2));
            measure(1'b1, per);
            exp = 2 * (s + 2) * (q + 1);
            check(per == exp, "R9 rate src x post", per, exp);
         end
      end

      // R8: stop the source the current branch uses
      put(1'b0, 7, 0);
      par = ~par;
      wait_idle(1'b0);
      b = int'(active_b);
      src_run[7] = 1'b0;
      #100;
      put(1'b0, 1, 0);
      #300;
      rise_cnt = 0;
      #2000;
      check(busy == 1'b1, "R8 busy held while stalled", int'(busy), 1);
      check(int'(active_b) == b, "R8 branch held while stalled", int'(active_b), b);
      check(rise_cnt == 0, "R8 output stalled", rise_cnt, 0);
      src_run[7] = 1'b1;
      par = ~par;
      wait_idle(1'b0);
      check(busy == 1'b0, "R8 switch completes on restart", int'(busy), 0);
      check(active_b == par, "R8 new branch active", int'(active_b), int'(par));
      measure(1'b0, per);
      check(per == 6, "R8 new rate after restart", per, 6);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule